// File: doc/BRIEF.md
# Multi-Mode Event Counter with Relational Comparator

This block counts events from one of two sources: rising edges of an already-filtered external pulse line, or ticks from an internal timebase that divides the system clock down to one of seven periods. Each event steps the count by one, upward or downward. In linear mode the count stops at the edge of the selected numeric range. In ring mode it cycles between a programmable low bound and high bound.

The numeric range can be 32-bit or 16-bit, signed or unsigned. A 16-bit count appears on the 32-bit output sign-extended or zero-extended, as the range requires. A load request writes a programmed value into the counter. A capture request copies the count into a holding register. A comparator tests the count against a programmed value using one of six relations. It registers the result and raises a single-cycle flag when the result becomes true.

Top module: `mmc_counter`

## Requirements
- R1: A count event is a rising edge of `ext_pulse` when `src_internal` is 0, or an internal tick when `src_internal` is 1. An event is taken only while `cnt_en` is 1. Each event changes `count` by exactly one at the clock edge where it is seen: upward when `count_down` is 0, downward when it is 1.
- R2: `tick_sel` codes 0 to 6 give one tick every N clock cycles. With TICKS_PER_100NS=4, N is 1, 2, 4, 40, 400, 4000 and 40000. Enabling the source resets the phase, so M enabled cycles yield floor(M/N) ticks. Code 7 yields no ticks.
- R3: With `ring_mode`=0, counting up at the range maximum leaves `count` unchanged. Counting down at the range minimum also leaves it unchanged.
- R4: With `ring_mode`=1, counting up from `ring_hi` loads `ring_lo`, and counting down from `ring_lo` loads `ring_hi`. Between the bounds the count steps by one.
- R5: `range_sel` encodings are 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 16-bit and 3 = unsigned 16-bit. In a 16-bit range, loaded, bound and compare values keep their low 16 bits, and `count` carries them sign-extended (range 2) or zero-extended (range 3).
- R6: `preset_req` loads the range-fitted `preset_val` at that clock edge. It takes priority over a count event in the same cycle.
- R7: `latch_req` makes `latch_val` take the value `count` held before that same clock edge.
- R8: `cmp_rel` codes are 0 equal, 1 greater, 2 less, 3 greater-or-equal, 4 less-or-equal and 5 not-equal, with `count` on the left side. Codes 6 and 7 are never true. The comparison uses the signedness of the range. `cmp_out` shows the result for the count one clock later.
- R9: `cmp_rise` is high for exactly the one cycle in which `cmp_out` goes from 0 to 1.
- R10: While reset is asserted, `count`, `latch_val`, `cmp_out` and `cmp_rise` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_internal | input | 1 | 1 = count internal ticks, 0 = count external edges |
| ext_pulse | input | 1 | Filtered external pulse line |
| tick_sel | input | 3 | Internal timebase period code |
| cnt_en | input | 1 | Count enable |
| count_down | input | 1 | 1 = subtract, 0 = add |
| ring_mode | input | 1 | 1 = ring, 0 = linear |
| range_sel | input | 2 | Numeric range code |
| preset_req | input | 1 | Load preset value |
| preset_val | input | 32 | Preset value |
| ring_lo | input | 32 | Ring lower bound |
| ring_hi | input | 32 | Ring upper bound |
| latch_req | input | 1 | Capture count |
| cmp_val | input | 32 | Compare value |
| cmp_rel | input | 3 | Compare relation code |
| count | output | 32 | Current count |
| latch_val | output | 32 | Captured count |
| cmp_out | output | 1 | Registered compare result |
| cmp_rise | output | 1 | One-cycle pulse on false-to-true compare |

## Verification
The count register is the only stored arithmetic state, so an error in it shows on `count` at the very edge where the faulty event, load or wrap is applied. The bench therefore samples right after each step. A wrong signedness or range limit produces a count that stops in the wrong place or wraps through zero. It also flips `cmp_out` one cycle later, because the comparator sees the same count. A wrong divider phase in the timebase appears as a tick total that is off by one after a fixed number of enabled cycles.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int CW = 32;
  localparam int HW = CW / 2;
  localparam int WW = CW + 2;

  typedef logic signed [WW-1:0] wide_t;

  typedef enum logic [1:0] {
    RG_S32 = 2'd0,
    RG_U32 = 2'd1,
    RG_S16 = 2'd2,
    RG_U16 = 2'd3
  } range_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_GT = 3'd1,
    REL_LT = 3'd2,
    REL_GE = 3'd3,
    REL_LE = 3'd4,
    REL_NE = 3'd5
  } rel_e;

  function automatic logic signed_rg(range_e r);
    return (r == RG_S32) || (r == RG_S16);
  endfunction

  // Squeeze a raw value into the representation of range r
  function automatic logic [CW-1:0] fit(logic [CW-1:0] v, range_e r);
    case (r)
      RG_S16:  fit = {{HW{v[HW-1]}}, v[HW-1:0]};
      RG_U16:  fit = {{HW{1'b0}}, v[HW-1:0]};
      default: fit = v;
    endcase
  endfunction

  function automatic wide_t widen(logic [CW-1:0] v, range_e r);
    if (signed_rg(r)) return $signed({{2{v[CW-1]}}, v});
    return $signed({2'b00, v});
  endfunction

  function automatic wide_t top_of(range_e r);
    case (r)
      RG_S32:  top_of = $signed({3'b000, {(CW-1){1'b1}}});
      RG_U32:  top_of = $signed({2'b00, {CW{1'b1}}});
      RG_S16:  top_of = $signed({{(WW-HW+1){1'b0}}, {(HW-1){1'b1}}});
      default: top_of = $signed({{(WW-HW){1'b0}}, {HW{1'b1}}});
    endcase
  endfunction

  function automatic wide_t bottom_of(range_e r);
    case (r)
      RG_S32:  bottom_of = $signed({3'b111, {(CW-1){1'b0}}});
      RG_S16:  bottom_of = $signed({{(WW-HW+1){1'b1}}, {(HW-1){1'b0}}});
      default: bottom_of = '0;
    endcase
  endfunction

  function automatic logic rel_hit(wide_t a, wide_t b, logic [2:0] rel);
    case (rel)
      REL_EQ:  rel_hit = (a == b);
      REL_GT:  rel_hit = (a > b);
      REL_LT:  rel_hit = (a < b);
      REL_GE:  rel_hit = (a >= b);
      REL_LE:  rel_hit = (a <= b);
      REL_NE:  rel_hit = (a != b);
      default: rel_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mmc_timebase.sv
module mmc_timebase #(
  parameter int unsigned TICKS_PER_100NS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int unsigned T  = TICKS_PER_100NS;
  localparam int unsigned NSEL = 7;
  localparam int unsigned D0 = (T / 4 > 0) ? T / 4 : 1;
  localparam int unsigned D1 = (T / 2 > 0) ? T / 2 : 1;
  localparam int unsigned DMAX = 10000 * T;
  localparam int DIVW = $clog2(DMAX + 1);

  logic [DIVW-1:0] lim [NSEL];
  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] cur_lim;
  logic            live;

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_lim
      localparam int unsigned DV = (i == 0) ? D0 :
                                   (i == 1) ? D1 :
                                   (i == 2) ? T :
                                   (i == 3) ? 10 * T :
                                   (i == 4) ? 100 * T :
                                   (i == 5) ? 1000 * T : DMAX;
      assign lim[i] = DIVW'(DV - 1);
    end
  endgenerate

  assign live    = run && (sel != 3'd7);
  assign cur_lim = (sel == 3'd7) ? '0 : lim[sel];
  assign tick    = live && (div_q >= cur_lim);

  always_ff @(posedge clk) begin
    if (!rst_n)              div_q <= '0;
    else if (!live || tick)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/mmc_core.sv
module mmc_core
  import mmc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          load,
  input  logic          down,
  input  logic          ring,
  input  range_e        rng,
  input  logic [CW-1:0] load_v,
  input  logic [CW-1:0] lo_v,
  input  logic [CW-1:0] hi_v,
  input  logic          grab,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] grab_q,
  output logic          at_top,
  output logic          at_bot
);
  wide_t cur, rlo, rhi, nxt;

  assign cur    = widen(count_q, rng);
  assign rlo    = widen(lo_v, rng);
  assign rhi    = widen(hi_v, rng);
  assign at_top = (cur >= top_of(rng));
  assign at_bot = (cur <= bottom_of(rng));

  always_comb begin
    nxt = cur;
    if (ring) begin
      if (!down) nxt = (cur >= rhi) ? rlo : cur + 1;
      else       nxt = (cur <= rlo) ? rhi : cur - 1;
    end else begin
      if (!down) nxt = at_top ? cur : cur + 1;
      else       nxt = at_bot ? cur : cur - 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      grab_q  <= '0;
    end else begin
      if (load)     count_q <= load_v;
      else if (evt) count_q <= nxt[CW-1:0];
      if (grab)     grab_q  <= count_q;
    end
  end
endmodule

// File: rtl/mmc_cmp.sv
module mmc_cmp
  import mmc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_v,
  input  logic [CW-1:0] ref_v,
  input  range_e        rng,
  input  logic [2:0]    rel,
  output logic          hit_now,
  output logic          hit_q,
  output logic          rise_q
);
  assign hit_now = rel_hit(widen(cnt_v, rng), widen(ref_v, rng), rel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      hit_q  <= hit_now;
      rise_q <= hit_now && !hit_q;
    end
  end
endmodule

// File: rtl/mmc_counter.sv
module mmc_counter
  import mmc_pkg::*;
#(
  parameter int unsigned TICKS_PER_100NS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_internal,
  input  logic        ext_pulse,
  input  logic [2:0]  tick_sel,
  input  logic        cnt_en,
  input  logic        count_down,
  input  logic        ring_mode,
  input  logic [1:0]  range_sel,
  input  logic        preset_req,
  input  logic [31:0] preset_val,
  input  logic [31:0] ring_lo,
  input  logic [31:0] ring_hi,
  input  logic        latch_req,
  input  logic [31:0] cmp_val,
  input  logic [2:0]  cmp_rel,
  output logic [31:0] count,
  output logic [31:0] latch_val,
  output logic        cmp_out,
  output logic        cmp_rise
);
  range_e        rng;
  logic          ext_q;
  logic          ext_edge;
  logic          int_tick;
  logic          count_evt;
  logic          at_top, at_bot;
  logic          hit_now;
  logic [CW-1:0] preset_fit, ring_lo_fit, ring_hi_fit, cmp_fit;

  assign rng         = range_e'(range_sel);
  assign preset_fit  = fit(preset_val, rng);
  assign ring_lo_fit = fit(ring_lo, rng);
  assign ring_hi_fit = fit(ring_hi, rng);
  assign cmp_fit     = fit(cmp_val, rng);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_pulse;
  end
  assign ext_edge = ext_pulse && !ext_q;

  mmc_timebase #(.TICKS_PER_100NS(TICKS_PER_100NS)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (cnt_en && src_internal),
    .sel  (tick_sel),
    .tick (int_tick)
  );

  assign count_evt = cnt_en && (src_internal ? int_tick : ext_edge);

  mmc_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (count_evt),
    .load   (preset_req),
    .down   (count_down),
    .ring   (ring_mode),
    .rng    (rng),
    .load_v (preset_fit),
    .lo_v   (ring_lo_fit),
    .hi_v   (ring_hi_fit),
    .grab   (latch_req),
    .count_q(count),
    .grab_q (latch_val),
    .at_top (at_top),
    .at_bot (at_bot)
  );

  mmc_cmp u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_v  (count),
    .ref_v  (cmp_fit),
    .rng    (rng),
    .rel    (cmp_rel),
    .hit_now(hit_now),
    .hit_q  (cmp_out),
    .rise_q (cmp_rise)
  );
endmodule

// File: rtl/mmc_counter_chk.sv
module mmc_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        count_evt,
  input logic        preset_req,
  input logic        count_down,
  input logic        ring_mode,
  input logic        at_top,
  input logic        at_bot,
  input logic [31:0] count,
  input logic [31:0] preset_fit,
  input logic [31:0] ring_lo_fit,
  input logic [31:0] ring_hi_fit,
  input logic        latch_req,
  input logic [31:0] latch_val,
  input logic        cmp_out,
  input logic        cmp_rise
);
  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && !preset_req && !count_down && !ring_mode && !at_top)
      |=> (count == $past(count) + 32'd1));

  a_r3_linear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && !preset_req && !ring_mode && (count_down ? at_bot : at_top))
      |=> $stable(count));

  a_r4_ring_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && !preset_req && ring_mode && !count_down && (count == ring_hi_fit))
      |=> (count == $past(ring_lo_fit)));

  a_r6_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    preset_req |=> (count == $past(preset_fit)));

  a_r7_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> (latch_val == $past(count)));

  a_r9_rise_with_out: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rise |-> cmp_out);

  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rise |=> !cmp_rise);
endmodule

bind mmc_counter mmc_counter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_evt  (count_evt),
  .preset_req (preset_req),
  .count_down (count_down),
  .ring_mode  (ring_mode),
  .at_top     (at_top),
  .at_bot     (at_bot),
  .count      (count),
  .preset_fit (preset_fit),
  .ring_lo_fit(ring_lo_fit),
  .ring_hi_fit(ring_hi_fit),
  .latch_req  (latch_req),
  .latch_val  (latch_val),
  .cmp_out    (cmp_out),
  .cmp_rise   (cmp_rise)
);

// File: tb/tb_mmc_counter.sv
`timescale 1ns/1ps
module tb_mmc_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_internal = 1'b1;
  logic        ext_pulse = 1'b0;
  logic [2:0]  tick_sel = 3'd0;
  logic        cnt_en = 1'b0;
  logic        count_down = 1'b0;
  logic        ring_mode = 1'b0;
  logic [1:0]  range_sel = 2'd0;
  logic        preset_req = 1'b0;
  logic [31:0] preset_val = '0;
  logic [31:0] ring_lo = '0;
  logic [31:0] ring_hi = '0;
  logic        latch_req = 1'b0;
  logic [31:0] cmp_val = '0;
  logic [2:0]  cmp_rel = 3'd0;
  logic [31:0] count, latch_val;
  logic        cmp_out, cmp_rise;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmc_counter dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint as_val(logic [31:0] c, int rg);
    if (rg == 0 || rg == 2) return longint'($signed(c));
    return longint'({32'b0, c});
  endfunction

  function automatic longint hi_of(int rg);
    case (rg)
      0: return 64'sd2147483647;
      1: return 64'sd4294967295;
      2: return 64'sd32767;
      default: return 64'sd65535;
    endcase
  endfunction

  function automatic longint lo_of(int rg);
    case (rg)
      0: return -64'sd2147483648;
      2: return -64'sd32768;
      default: return 64'sd0;
    endcase
  endfunction

  function automatic bit rel_ref(longint a, longint b, int r);
    case (r)
      0: return a == b;
      1: return a > b;
      2: return a < b;
      3: return a >= b;
      4: return a <= b;
      5: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic load(longint v);
    @(negedge clk);
    preset_val = 32'(v);
    preset_req = 1'b1;
    @(negedge clk);
    preset_req = 1'b0;
  endtask

  task automatic run_int(int sel, int m);
    @(negedge clk);
    src_internal = 1'b1;
    tick_sel = 3'(sel);
    cnt_en = 1'b1;
    repeat (m) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 count", count, 0);
    chk("R10 latch_val", latch_val, 0);
    chk("R10 cmp_out", cmp_out, 0);
    chk("R10 cmp_rise", cmp_rise, 0);
    rst_n = 1'b1;
    cmp_rel = 3'd7;

    // R2 timebase codes, R1 internal source
    begin
      int sels [6] = '{0, 1, 2, 3, 4, 7};
      int cyc  [6] = '{20, 20, 20, 200, 1200, 50};
      int divs [6] = '{1, 2, 4, 40, 400, 0};
      range_sel = 2'd1;
      for (int i = 0; i < 6; i++) begin
        load(0);
        run_int(sels[i], cyc[i]);
        chk($sformatf("R2 tick code %0d", sels[i]), count,
            divs[i] == 0 ? 0 : cyc[i] / divs[i]);
      end
    end

    // R1 external edges, disabled edges ignored, held level counts once
    load(10);
    @(negedge clk);
    src_internal = 1'b0;
    cnt_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      ext_pulse = 1'b1; @(negedge clk);
      ext_pulse = 1'b0; @(negedge clk);
    end
    chk("R1 external edges", count, 17);
    ext_pulse = 1'b1; repeat (6) @(negedge clk);
    ext_pulse = 1'b0; @(negedge clk);
    chk("R1 held level one step", count, 18);
    cnt_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ext_pulse = 1'b1; @(negedge clk);
      ext_pulse = 1'b0; @(negedge clk);
    end
    chk("R1 disabled edges ignored", count, 18);
    count_down = 1'b1;
    run_int(0, 5);
    chk("R1 count down", count, 13);
    count_down = 1'b0;

    // R3 linear saturation, every range and direction
    for (int rg = 0; rg < 4; rg++) begin
      for (int d = 0; d < 2; d++) begin
        range_sel = 2'(rg);
        count_down = d[0];
        load(d ? lo_of(rg) + 2 : hi_of(rg) - 2);
        run_int(0, 5);
        chk($sformatf("R3 range %0d dir %0d", rg, d), as_val(count, rg),
            d ? lo_of(rg) : hi_of(rg));
      end
    end
    count_down = 1'b0;

    // R4 ring up in unsigned 16, bounds 3..7
    ring_mode = 1'b1;
    range_sel = 2'd3;
    ring_lo = 32'd3;
    ring_hi = 32'd7;
    load(3);
    for (int i = 1; i <= 12; i++) begin
      run_int(0, 1);
      chk($sformatf("R4 ring up step %0d", i), as_val(count, 3), 3 + (i % 5));
    end
    // R4 ring down in signed 16, bounds -2..2
    range_sel = 2'd2;
    ring_lo = 32'hFFFF_FFFE;
    ring_hi = 32'd2;
    count_down = 1'b1;
    load(2);
    for (int i = 1; i <= 12; i++) begin
      run_int(0, 1);
      chk($sformatf("R4 ring down step %0d", i), as_val(count, 2), 2 - (i % 5));
    end
    count_down = 1'b0;
    ring_mode = 1'b0;

    // R5 range fitting of loaded values
    range_sel = 2'd3;
    load(64'h12345);
    chk("R5 u16 fit", count, 32'h0000_2345);
    range_sel = 2'd2;
    load(64'h18000);
    chk("R5 s16 fit", count, 32'hFFFF_8000);

    // R6 preset beats simultaneous event
    range_sel = 2'd0;
    load(0);
    @(negedge clk);
    src_internal = 1'b1; tick_sel = 3'd0; cnt_en = 1'b1;
    preset_val = 32'd500; preset_req = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; preset_req = 1'b0;
    chk("R6 preset priority", count, 500);

    // R7 latch takes pre-edge count
    @(negedge clk);
    latch_req = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    latch_req = 1'b0; cnt_en = 1'b0;
    chk("R7 latch value", latch_val, 500);
    chk("R7 count moved", count, 501);

    // R8 compare sweep, signed 16
    range_sel = 2'd2;
    cmp_val = 32'd5;
    for (int v = -3; v <= 8; v++) begin
      for (int r = 0; r < 8; r++) begin
        cmp_rel = 3'(r);
        load(v);
        @(negedge clk);
        chk($sformatf("R8 s16 v=%0d rel=%0d", v, r), cmp_out, rel_ref(v, 5, r));
      end
    end
    // R8 signedness at 32 bits
    cmp_val = 32'd1;
    cmp_rel = 3'd1;
    range_sel = 2'd1;
    load(64'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 u32 greater", cmp_out, 1);
    range_sel = 2'd0;
    load(64'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 s32 greater", cmp_out, 0);

    // R9 single rise pulse while sweeping past the compare value
    begin
      int rises = 0;
      int rise_at = -1;
      range_sel = 2'd2;
      cmp_val = 32'd5;
      cmp_rel = 3'd0;
      load(0);
      @(negedge clk);
      chk("R9 idle low", cmp_rise, 0);
      src_internal = 1'b1; tick_sel = 3'd0; cnt_en = 1'b1;
      for (int i = 1; i <= 10; i++) begin
        @(negedge clk);
        if (cmp_rise) begin
          rises++;
          rise_at = i;
        end
      end
      cnt_en = 1'b0;
      chk("R9 rise count", rises, 1);
      chk("R9 rise cycle", rise_at, 6);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule